// File: doc/BRIEF.md
# Serial EEPROM Slave Front End

This block is the digital side of a small serial EEPROM that a host reaches over a four-wire SPI slave port with an extra write-protect input. The host frames each transaction with chip select. The first byte is a command. Depending on that command the block then takes a two-byte address and data, returns stored bytes, or returns or updates a status byte. The SPI pins are brought into the block's own clock domain through synchronizers, and all work is done on that faster clock.

Write data first goes into a 32-byte page buffer. When chip select rises after a clean sequence of whole bytes, a timed internal write cycle starts. During that cycle the buffered bytes are copied into a synchronous RAM of 1 KiB or 2 KiB. While the cycle runs, the block accepts only status reads. A write-enable latch guards every change to the memory or to the status byte. A protect-enable status bit, together with the protect pin, can lock the status byte.

Top module: `spi_eeprom`

## Requirements
- R1: Input bits are taken on SCK rising edges and output bits change on SCK falling edges, most significant bit first. This works with SCK idling low or idling high (SPI modes 0 and 3).
- R2: While chip select is high, `miso_oe` is 0 and the command decoder is idle. A falling chip select starts a new transaction at its command byte.
- R3: Command codes are 0x06 set write-enable, 0x04 clear write-enable, 0x05 read status, 0x01 write status, 0x03 read and 0x02 write. The status byte has busy in bit 0, write-enable in bit 1 and protect-enable in bit 7, and reads as 0x00 after reset. A status read repeats the current status for as long as clocking continues.
- R4: A status write loads only bit 7. It is refused when `wp_n` is 0 and bit 7 is already 1, and it is accepted whenever `wp_n` is 1. An accepted status write also runs a write cycle.
- R5: A write or a status write that arrives while the write-enable latch is clear is ignored. Command 0x06 sets the latch and 0x04 clears it.
- R6: A write cycle starts at the rising chip select that ends a valid write. Busy reads 1 for WR_CYCLES clock cycles, and afterwards the new data reads back.
- R7: Write data bytes go to consecutive locations whose low five address bits wrap inside the 32-byte page. Bytes outside the written locations keep their contents.
- R8: A read returns bytes from consecutive addresses, wrapping from the last byte of the array to address 0.
- R9: The write-enable latch clears when a write cycle ends.
- R10: While busy, every command except status read is ignored, including a further write.
- R11: A write whose chip select rises partway through a byte is abandoned. No cycle starts and the memory is unchanged.
- R12: The byte address is 11 bits (HIGH_DENSITY=1) or 10 bits wide, and address bits above that width are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; must run at least 6 times faster than SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock |
| mosi | input | 1 | Serial data from the host |
| wp_n | input | 1 | Write-protect pin; low together with protect-enable locks status |
| miso | output | 1 | Serial data to the host |
| miso_oe | output | 1 | Output enable for `miso`; 0 means high impedance |

## Verification
The hardest case to reach is a command that arrives while the internal write cycle is still running. The write-enable latch is still set at that point, so only the busy gate can stop a second write. The bench therefore sends a second complete write right after the first one, well inside a short WR_CYCLES setting. It then reads the page back and expects the first data. A write cut off four bits into a byte, and status writes made with the protect pin both low and high, cover the other paths that leave state untouched.

// File: rtl/spi_eeprom_pkg.sv
package spi_eeprom_pkg;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;

  localparam int PAGE_BYTES = 32;
  localparam int PAGE_IW    = $clog2(PAGE_BYTES);

  typedef enum logic [2:0] {
    PH_CMD, PH_AHI, PH_ALO, PH_RD, PH_WR, PH_SOUT, PH_SIN, PH_SKIP
  } phase_e;
endpackage

// File: rtl/ee_sync.sv
module ee_sync #(
  parameter int          WIDTH   = 4,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] pipe_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe_q[i] <= RST_VAL;
    end else begin
      pipe_q[0] <= din;
      for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
    end
  end

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/ee_wr_timer.sv
module ee_wr_timer #(
  parameter int CYCLES = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    done  = 1'b0;
    if (start) begin
      cnt_d = CW'(CYCLES);
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
      done  = (cnt_q == CW'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

// File: rtl/ee_page_buf.sv
module ee_page_buf #(
  parameter int BYTES = 32,
  localparam int IW = $clog2(BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [7:0]    wr_data,
  input  logic          clr,
  input  logic [IW-1:0] rd_idx,
  output logic [7:0]    rd_data,
  output logic          rd_hit,
  output logic          any
);
  logic [7:0]       data_q [BYTES];
  logic [BYTES-1:0] mask_q, mask_d;

  always_comb begin
    mask_d = mask_q;
    if (clr)        mask_d = '0;
    else if (wr_en) mask_d[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) data_q[wr_idx] <= wr_data;
  end

  assign rd_data = data_q[rd_idx];
  assign rd_hit  = mask_q[rd_idx];
  assign any     = |mask_q;

  // R7
  pb_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr) |=> any);
endmodule

// File: rtl/ee_ram.sv
module ee_ram #(
  parameter int AW = 11,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    rdata     <= mem[addr];
    end
  end
endmodule

// File: rtl/spi_eeprom.sv
module spi_eeprom
  import spi_eeprom_pkg::*;
#(
  parameter bit HIGH_DENSITY = 1'b1,
  parameter int WR_CYCLES    = 250000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  input  logic wp_n,
  output logic miso,
  output logic miso_oe
);
  localparam int AW = HIGH_DENSITY ? 11 : 10;

  logic [1:0] rst_pipe_q;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_s = rst_pipe_q[1];

  logic [3:0] pins_s;
  ee_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1001)) u_sync (
    .clk(clk), .rst_n(rst_s), .din({cs_n, sck, mosi, wp_n}), .q(pins_s));

  logic cs_s, sck_s, mosi_s, wp_s;
  assign {cs_s, sck_s, mosi_s, wp_s} = pins_s;

  logic cs_p_q, sck_p_q;
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      cs_p_q  <= 1'b1;
      sck_p_q <= 1'b0;
    end else begin
      cs_p_q  <= cs_s;
      sck_p_q <= sck_s;
    end
  end

  logic cs_rise, cs_fall, sck_rise, sck_fall;
  assign cs_rise  = cs_s & ~cs_p_q;
  assign cs_fall  = ~cs_s & cs_p_q;
  assign sck_rise = ~cs_s & sck_s & ~sck_p_q;
  assign sck_fall = ~cs_s & ~sck_s & sck_p_q;

  phase_e        ph_q, ph_d;
  logic [2:0]    bit_q, bit_d;
  logic [7:0]    sh_q, sh_d, out_q, out_d;
  logic          miso_q, miso_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [PAGE_IW-1:0] pidx_q, pidx_d, cptr_q, cptr_d;
  logic          is_wr_q, is_wr_d, wel_q, wel_d, wpen_q, wpen_d;
  logic          sr_new_q, sr_new_d, sr_got_q, sr_got_d;
  logic          rd_req_q, rd_req_d, rd_vld_q, rd_vld_d, cact_q, cact_d;

  logic       busy, done, wr_start, pb_wr, pb_clr, pb_hit, pb_any, ram_we;
  logic [7:0] pb_rdata, ram_rdata, rx_byte, status;
  logic       byte_done, locked;

  assign rx_byte   = {sh_q[6:0], mosi_s};
  assign byte_done = sck_rise && (bit_q == 3'd7);
  assign status    = {wpen_q, 5'b00000, wel_q, busy};
  assign locked    = ~wp_s & wpen_q;

  always_comb begin
    ph_d = ph_q; bit_d = bit_q; sh_d = sh_q; out_d = out_q; miso_d = miso_q;
    addr_d = addr_q; pidx_d = pidx_q; is_wr_d = is_wr_q; wel_d = wel_q;
    wpen_d = wpen_q; sr_new_d = sr_new_q; sr_got_d = sr_got_q;
    rd_req_d = 1'b0; rd_vld_d = rd_req_q; cptr_d = cptr_q; cact_d = cact_q;
    pb_wr = 1'b0; pb_clr = 1'b0; wr_start = 1'b0;

    if (cs_fall) begin
      ph_d = PH_CMD; bit_d = 3'd0; sr_got_d = 1'b0;
    end
    if (sck_fall) begin
      miso_d = out_q[7];
      out_d  = {out_q[6:0], 1'b0};
    end
    if (rd_vld_q) begin
      out_d  = ram_rdata;
      addr_d = addr_q + 1'b1;
    end
    if (sck_rise) begin
      bit_d = bit_q + 3'd1;
      sh_d  = rx_byte;
    end
    if (byte_done) begin
      unique case (ph_q)
        PH_CMD: begin
          ph_d = PH_SKIP;
          if (!busy || rx_byte == OP_RDSR) begin
            case (rx_byte)
              OP_WREN:  wel_d = 1'b1;
              OP_WRDI:  wel_d = 1'b0;
              OP_RDSR:  begin ph_d = PH_SOUT; out_d = status; end
              OP_WRSR:  if (wel_q) ph_d = PH_SIN;
              OP_READ:  begin ph_d = PH_AHI; is_wr_d = 1'b0; end
              OP_WRITE: if (wel_q) begin ph_d = PH_AHI; is_wr_d = 1'b1; end
              default:  ;
            endcase
          end
        end
        PH_AHI: begin
          addr_d = AW'({rx_byte, 8'h00});
          ph_d   = PH_ALO;
        end
        PH_ALO: begin
          addr_d = {addr_q[AW-1:8], rx_byte};
          pidx_d = rx_byte[PAGE_IW-1:0];
          if (is_wr_q) ph_d = PH_WR;
          else begin ph_d = PH_RD; rd_req_d = 1'b1; end
        end
        PH_RD:   rd_req_d = 1'b1;
        PH_WR:   begin pb_wr = 1'b1; pidx_d = pidx_q + 1'b1; end
        PH_SOUT: out_d = status;
        PH_SIN:  begin sr_new_d = rx_byte[7]; sr_got_d = 1'b1; ph_d = PH_SKIP; end
        default: ;
      endcase
    end
    if (cs_rise) begin
      ph_d = PH_CMD; bit_d = 3'd0; sr_got_d = 1'b0;
      if (bit_q == 3'd0 && ph_q == PH_WR && pb_any) begin
        wr_start = 1'b1;
      end else if (bit_q == 3'd0 && sr_got_q && !locked) begin
        wpen_d = sr_new_q; wr_start = 1'b1;
      end
      if (!wr_start && !busy) pb_clr = 1'b1;
    end
    if (wr_start) begin
      cact_d = 1'b1; cptr_d = '0;
    end else if (cact_q) begin
      cptr_d = cptr_q + 1'b1;
      if (cptr_q == '1) cact_d = 1'b0;
    end
    if (done) begin
      wel_d = 1'b0; pb_clr = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      ph_q <= PH_CMD; bit_q <= '0; sh_q <= '0; out_q <= '0; miso_q <= 1'b0;
      addr_q <= '0; pidx_q <= '0; is_wr_q <= 1'b0; wel_q <= 1'b0;
      wpen_q <= 1'b0; sr_new_q <= 1'b0; sr_got_q <= 1'b0; rd_req_q <= 1'b0;
      rd_vld_q <= 1'b0; cptr_q <= '0; cact_q <= 1'b0;
    end else begin
      ph_q <= ph_d; bit_q <= bit_d; sh_q <= sh_d; out_q <= out_d; miso_q <= miso_d;
      addr_q <= addr_d; pidx_q <= pidx_d; is_wr_q <= is_wr_d; wel_q <= wel_d;
      wpen_q <= wpen_d; sr_new_q <= sr_new_d; sr_got_q <= sr_got_d;
      rd_req_q <= rd_req_d; rd_vld_q <= rd_vld_d; cptr_q <= cptr_d; cact_q <= cact_d;
    end
  end

  ee_wr_timer #(.CYCLES(WR_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_s), .start(wr_start), .busy(busy), .done(done));

  ee_page_buf #(.BYTES(PAGE_BYTES)) u_pbuf (
    .clk(clk), .rst_n(rst_s), .wr_en(pb_wr), .wr_idx(pidx_q), .wr_data(rx_byte),
    .clr(pb_clr), .rd_idx(cptr_q), .rd_data(pb_rdata), .rd_hit(pb_hit), .any(pb_any));

  assign ram_we = cact_q & pb_hit;

  ee_ram #(.AW(AW)) u_ram (
    .clk(clk), .en(rd_req_q | ram_we), .we(ram_we),
    .addr(ram_we ? {addr_q[AW-1:PAGE_IW], cptr_q} : addr_q),
    .wdata(pb_rdata), .rdata(ram_rdata));

  assign miso_oe = ~cs_s;
  assign miso    = miso_q & ~cs_s;

  // R6
  ram_wr_busy_chk: assert property (@(posedge clk) disable iff (!rst_s)
    ram_we |-> busy);
  // R9
  wel_clr_chk: assert property (@(posedge clk) disable iff (!rst_s)
    done |=> !wel_q);
  // R4
  wpen_lock_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (locked && cs_rise) |=> wpen_q);
  // R11
  abandon_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (cs_rise && bit_q != 3'd0 && !busy) |=> !busy);
endmodule

// File: tb/spi_eeprom_bench.sv
module spi_eeprom_bench;
  localparam int HB     = 6;
  localparam int WR_CYC = 200;
  localparam int AW     = 11;

  logic clk = 1'b0;
  logic rst_n, cs_n, sck, mosi, wp_n, mode3;
  logic miso, miso_oe;
  int   checks = 0, errors = 0;
  bit   finished = 1'b0;

  logic [7:0] model [2048];
  bit         known [2048];
  logic [7:0] wbuf [32];
  logic [7:0] rbuf [40];

  always #5 clk = ~clk;

  spi_eeprom #(.HIGH_DENSITY(1'b1), .WR_CYCLES(WR_CYC)) u_spi_eeprom (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .wp_n(wp_n), .miso(miso), .miso_oe(miso_oe));

  function automatic logic [7:0] stat(input bit wpen, input bit wel, input bit bsy);
    return {wpen, 5'b00000, wel, bsy};
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nbits; i--) begin
      sck = 1'b0; mosi = tx[i];
      wclk(HB);
      rx[i] = miso;
      sck = 1'b1;
      wclk(HB);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    xfer_bits(tx, 8, rx);
  endtask

  task automatic tx_begin();
    sck = mode3; cs_n = 1'b0;
    wclk(HB);
  endtask

  task automatic tx_end();
    if (!mode3) begin wclk(HB); sck = 1'b0; end
    wclk(HB);
    cs_n = 1'b1;
    wclk(2 * HB);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] r;
    tx_begin(); xfer(op, r); tx_end();
  endtask

  task automatic rdsr(output logic [7:0] st);
    logic [7:0] r;
    tx_begin(); xfer(8'h05, r); xfer(8'h00, st); tx_end();
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] r;
    tx_begin(); xfer(8'h01, r); xfer(v, r); tx_end();
  endtask

  task automatic page_write(input logic [15:0] a, input int n);
    logic [7:0] r;
    tx_begin();
    xfer(8'h02, r); xfer(a[15:8], r); xfer(a[7:0], r);
    for (int i = 0; i < n; i++) xfer(wbuf[i], r);
    tx_end();
  endtask

  task automatic model_write(input logic [15:0] a, input int n);
    for (int i = 0; i < n; i++) begin
      logic [4:0]    lo;
      logic [AW-1:0] idx;
      lo  = a[4:0] + 5'(i);
      idx = {a[AW-1:5], lo};
      model[idx] = wbuf[i];
      known[idx] = 1'b1;
    end
  endtask

  task automatic read_seq(input logic [15:0] a, input int n);
    logic [7:0] r;
    tx_begin();
    xfer(8'h03, r); xfer(a[15:8], r); xfer(a[7:0], r);
    for (int i = 0; i < n; i++) xfer(8'h00, rbuf[i]);
    tx_end();
  endtask

  task automatic verify(input logic [15:0] a, input int n, input string tag);
    read_seq(a, n);
    for (int i = 0; i < n; i++) begin
      logic [AW-1:0] idx;
      idx = AW'(a) + AW'(i);
      if (known[idx]) check(tag, rbuf[i], model[idx]);
    end
  endtask

  task automatic wait_ready();
    logic [7:0] st;
    for (int k = 0; k < 100; k++) begin
      rdsr(st);
      if (!st[0]) break;
    end
  endtask

  task automatic fill(input logic [7:0] base, input int n);
    for (int i = 0; i < n; i++) wbuf[i] = base + 8'(i * 7);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] st;
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 2048; i++) known[i] = 1'b0;
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; mosi = 1'b0; wp_n = 1'b1; mode3 = 1'b0;
    wclk(5);
    check("R2 oe in reset", {7'b0, miso_oe}, 8'h00);
    rst_n = 1'b1;
    wclk(5);
    check("R2 oe idle", {7'b0, miso_oe}, 8'h00);

    rdsr(st); check("R3 status after reset", st, stat(0, 0, 0));
    cmd1(8'h06); rdsr(st); check("R5 latch set", st, stat(0, 1, 0));
    cmd1(8'h04); rdsr(st); check("R5 latch clear", st, stat(0, 0, 0));

    fill(8'h90, 4); page_write(16'h013C, 4);
    rdsr(st); check("R5 write without latch", st, stat(0, 0, 0));

    // R7 page wrap: 8 bytes at low bits 0x1C wrap to 0x00..0x03
    cmd1(8'h06); fill(8'h11, 8); page_write(16'h013C, 8);
    rdsr(st); check("R6 busy after write", st, stat(0, 1, 1));
    wait_ready();
    rdsr(st); check("R9 latch cleared by cycle", st, stat(0, 0, 0));
    model_write(16'h013C, 8);
    verify(16'h013C, 4, "R7 page tail");
    verify(16'h0120, 4, "R7 wrapped head");

    // R10 second write while busy must be dropped
    cmd1(8'h06); fill(8'hA0, 4); page_write(16'h0200, 4); model_write(16'h0200, 4);
    fill(8'h55, 4); page_write(16'h0200, 4);
    wait_ready();
    rdsr(st); check("R10 no second cycle", st, stat(0, 0, 0));
    verify(16'h0200, 4, "R10 data kept");

    // R11 write cut mid-byte
    cmd1(8'h06);
    begin
      logic [7:0] r;
      tx_begin();
      xfer(8'h02, r); xfer(8'h02, r); xfer(8'h00, r);
      xfer(8'hEE, r); xfer(8'hDD, r); xfer_bits(8'hAA, 4, r);
      tx_end();
    end
    rdsr(st); check("R11 abandoned, idle", st, stat(0, 1, 0));
    verify(16'h0200, 4, "R11 data kept");
    cmd1(8'h04);

    // R4 status lock
    cmd1(8'h06); wrsr(8'h80); wait_ready();
    rdsr(st); check("R4 protect bit set", st, stat(1, 0, 0));
    wp_n = 1'b0;
    cmd1(8'h06); wrsr(8'h00);
    rdsr(st); check("R4 locked write refused", st, stat(1, 1, 0));
    wp_n = 1'b1;
    wrsr(8'h00); wait_ready();
    rdsr(st); check("R4 unlocked write taken", st, stat(0, 0, 0));

    // R8 and R12 wrap at array end, high address bits ignored
    cmd1(8'h06); fill(8'h30, 16); page_write(16'h07F0, 16); model_write(16'h07F0, 16); wait_ready();
    cmd1(8'h06); fill(8'hC3, 4); page_write(16'h0000, 4); model_write(16'h0000, 4); wait_ready();
    verify(16'hFFFE, 6, "R8 R12 wrap at end");

    // R1 mode 3
    mode3 = 1'b1; sck = 1'b1; wclk(HB);
    verify(16'h07F4, 4, "R1 mode3 read");
    rdsr(st); check("R1 mode3 status", st, stat(0, 0, 0));
    mode3 = 1'b0; sck = 1'b0; wclk(HB);

    // R7 R8 random page writes and reads
    for (int it = 0; it < 10; it++) begin
      logic [15:0] a;
      int n;
      a = 16'($urandom());
      n = 1 + int'($urandom() % 32);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom());
      cmd1(8'h06); page_write(a, n); model_write(a, n); wait_ready();
      verify({5'b0, a[10:5], 5'b0}, 32, "R7 R8 random");
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule